// File: doc/BRIEF.md
# Dual-Address SMBus Thermal Reporting Target

This block is an SMBus target through which an external management controller exchanges thermal information with the chip. It listens on two 7-bit addresses, both set from configuration inputs and expected to differ. The first is a write-only address. Its first data byte selects a control register, and the bytes after it fill the controller-written register file, one register after another. The second is a read-only address. It serves one operation: a Block Read with command code 40h. The target answers that read with a byte count, then the thermal data bytes, then a packet error code byte when that code is enabled.

The bus lines reach the block as raw input levels. They pass through a two-stage synchroniser and are sampled on the system clock. The block pulls SDA through a single open-drain pull-down output. It pulls only for its acknowledge slots and for zero bits of the bytes it sends. Nothing is acknowledged unless the power-state input shows the system awake.

A separate active-low alert output combines limit-exceeded flags with per-flag enable bits.

Top module: `thermal_smb_target`

## Requirements
- R1: A write to the write address is acknowledged on every byte. The first data byte loads the register pointer. Each later byte is stored into control register number *pointer*, which appears on `ctrl_regs_o[8*p+7:8*p]`, and the pointer then advances. Bytes that arrive while the pointer is NREG or above are acknowledged and discarded.
- R2: An address byte with the read bit set (bit 0 = 1) that carries the write address is not acknowledged: SDA stays released in its acknowledge slot.
- R3: In the write direction, the block-read address acknowledges exactly one data byte, and only if that byte equals 40h. Any other command value is not acknowledged, and neither is a second data byte.
- R4: A read-direction address byte that carries the block-read address is acknowledged only if 40h was accepted earlier in the same transaction, meaning since the START that followed a bus-free condition. Otherwise it is not acknowledged.
- R5: After an acknowledged block-read address, the target sends bytes MSB first, each following a host acknowledge. The first byte is the count NBYTES. It is followed by data bytes 0 to NBYTES-1, where byte k is `blk_data_i[8k+7:8k]`.
- R6: When `pec_en_i` is 1, one more byte follows the last data byte. That byte is the CRC-8 (polynomial x^8+x^2+x+1, initial value 0, MSB first) of every byte of the transaction: both address bytes, the command, the count and the data. When `pec_en_i` is 0, nothing follows the last data byte.
- R7: While `sys_awake_i` is 0, no address is acknowledged.
- R8: `alert_n_o` is 0 exactly when some bit position i has both `limit_flag_i[i]` and `alert_en_i[i]` set. It follows its inputs one clock cycle later.
- R9: A STOP at any point returns the target to idle and releases SDA. A START at any point restarts address reception. After either, a well-formed transaction is served normally.
- R10: The target releases SDA after the host's acknowledge or not-acknowledge on the final byte. It also releases SDA whenever it is idle. It starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| sys_awake_i | input | 1 | 1 when the system is in a working or light-sleep state |
| wr_addr_i | input | 7 | Write-only target address |
| rd_addr_i | input | 7 | Block-read target address |
| pec_en_i | input | 1 | Append the packet error code byte to block reads |
| blk_data_i | input | NBYTES*8 | Thermal data bytes served by block read, byte 0 in the low bits |
| ctrl_regs_o | output | NREG*8 | Controller-written register file, register 0 in the low bits |
| limit_flag_i | input | NFLAG | Limit-exceeded flags |
| alert_en_i | input | NFLAG | Alert enable bit per flag |
| alert_n_o | output | 1 | Active-low alert |

## Verification
The assertions rely on the host behaving like a well-formed SMBus master. Data on SDA changes only while SCL is low. Each SCL phase lasts several system clocks, longer than the synchroniser and decode latency. START and STOP are issued only while the target is not pulling SDA low. The addresses are also assumed to differ.

The bench's host model keeps to all of this. It holds each SCL half-period at eight clocks and moves SDA only at the start of a low phase. It issues STOP or repeated START only after the acknowledge slot, or in the middle of a byte the target is receiving. The two addresses are fixed at distinct values throughout.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RXB,
    ST_ACK,
    ST_TXB,
    ST_HACK,
    ST_IGNORE
  } smbt_state_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_WR,
    TGT_RDW,
    TGT_RDR
  } smbt_tgt_e;

  localparam logic [7:0] BLK_CMD = 8'h40;

  // Byte-wise CRC-8, polynomial 0x07, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/smbt_line.sv
module smbt_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] scl_sh;
  logic [DEPTH-1:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_raw};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_raw};
    end
  end

  logic scl_prev;
  logic sda_prev;

  assign scl_lvl   = scl_sh[DEPTH-2];
  assign sda_lvl   = sda_sh[DEPTH-2];
  assign scl_prev  = scl_sh[DEPTH-1];
  assign sda_prev  = sda_sh[DEPTH-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/smbt_alert.sv
module smbt_alert #(
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] enables,
  output logic             alert_n
);

  logic alert_n_d;

  always_comb alert_n_d = ~|(flags & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alert_n <= 1'b1;
    else        alert_n <= alert_n_d;
  end

endmodule

// File: rtl/smbt_txsel.sv
module smbt_txsel #(
  parameter int NBYTES = 8,
  parameter int IDXW   = 4
) (
  input  logic [IDXW-1:0]     idx,
  input  logic [NBYTES*8-1:0] data,
  input  logic [7:0]          crc,
  output logic [7:0]          tx_byte
);

  localparam int NSLOT = NBYTES + 2;

  logic [NSLOT-1:0][7:0] slot;

  assign slot[0]       = 8'(NBYTES);
  assign slot[NSLOT-1] = crc;

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    assign slot[g+1] = data[8*g +: 8];
  end

  always_comb begin
    tx_byte = 8'hFF;
    for (int i = 0; i < NSLOT; i++) begin
      if (idx == IDXW'(i)) tx_byte = slot[i];
    end
  end

endmodule

// File: rtl/thermal_smb_target.sv
module thermal_smb_target
  import smbt_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int NREG   = 4,
  parameter int NFLAG  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_pull_o,
  input  logic                sys_awake_i,
  input  logic [6:0]          wr_addr_i,
  input  logic [6:0]          rd_addr_i,
  input  logic                pec_en_i,
  input  logic [NBYTES*8-1:0] blk_data_i,
  output logic [NREG*8-1:0]   ctrl_regs_o,
  input  logic [NFLAG-1:0]    limit_flag_i,
  input  logic [NFLAG-1:0]    alert_en_i,
  output logic                alert_n_o
);

  localparam int IDXW = $clog2(NBYTES + 3);
  localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_q_n = rst_sh[1];

  // line conditioning
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  smbt_line #(.SYNC_STAGES(2)) u_line (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .scl_raw  (scl_i),
    .sda_raw  (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  smbt_alert #(.NFLAG(NFLAG)) u_alert (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .flags  (limit_flag_i),
    .enables(alert_en_i),
    .alert_n(alert_n_o)
  );

  // protocol state
  smbt_state_e     st, st_n;
  smbt_tgt_e       tgt, tgt_n;
  logic [7:0]      sr, sr_n;
  logic [3:0]      bcnt, bcnt_n;
  logic            drv, drv_n;
  logic            first, first_n;
  logic [7:0]      ptr, ptr_n;
  logic            cmd_ok, cmd_ok_n;
  logic            busy, busy_n;
  logic [7:0]      crc, crc_n;
  logic [IDXW-1:0] tidx, tidx_n;
  logic [7:0]      txsr, txsr_n;
  logic            hack, hack_n;
  logic            go_tx, go_tx_n;
  logic            wr_en;
  logic [SELW-1:0] wr_sel;
  logic [7:0]      tx_byte;
  logic [IDXW-1:0] last_idx;

  smbt_txsel #(.NBYTES(NBYTES), .IDXW(IDXW)) u_txsel (
    .idx    (tidx),
    .data   (blk_data_i),
    .crc    (crc),
    .tx_byte(tx_byte)
  );

  assign last_idx = pec_en_i ? IDXW'(NBYTES + 1) : IDXW'(NBYTES);
  assign wr_sel   = ptr[SELW-1:0];

  always_comb begin
    st_n     = st;
    tgt_n    = tgt;
    sr_n     = sr;
    bcnt_n   = bcnt;
    drv_n    = drv;
    first_n  = first;
    ptr_n    = ptr;
    cmd_ok_n = cmd_ok;
    busy_n   = busy;
    crc_n    = crc;
    tidx_n   = tidx;
    txsr_n   = txsr;
    hack_n   = hack;
    go_tx_n  = go_tx;
    wr_en    = 1'b0;

    if (stop_det) begin
      st_n     = ST_IDLE;
      drv_n    = 1'b0;
      busy_n   = 1'b0;
      cmd_ok_n = 1'b0;
    end else if (start_det) begin
      st_n   = ST_ADDR;
      bcnt_n = 4'd0;
      drv_n  = 1'b0;
      busy_n = 1'b1;
      if (!busy) begin
        crc_n    = 8'h00;
        cmd_ok_n = 1'b0;
      end
    end else begin
      case (st)
        ST_ADDR, ST_RXB: begin
          if (scl_rise && bcnt != 4'd8) begin
            sr_n   = {sr[6:0], sda_lvl};
            bcnt_n = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            bcnt_n = 4'd0;
            crc_n  = crc8_step(crc, sr);
            if (st == ST_ADDR) begin
              if (!sys_awake_i) begin
                st_n = ST_IGNORE;
              end else if (sr[7:1] == wr_addr_i && !sr[0]) begin
                st_n = ST_ACK; drv_n = 1'b1; tgt_n = TGT_WR;
                first_n = 1'b1; go_tx_n = 1'b0;
              end else if (sr[7:1] == rd_addr_i && !sr[0]) begin
                st_n = ST_ACK; drv_n = 1'b1; tgt_n = TGT_RDW;
                first_n = 1'b1; go_tx_n = 1'b0;
              end else if (sr[7:1] == rd_addr_i && sr[0] && cmd_ok) begin
                st_n = ST_ACK; drv_n = 1'b1; tgt_n = TGT_RDR;
                go_tx_n = 1'b1; tidx_n = '0;
              end else begin
                st_n = ST_IGNORE;
              end
            end else begin
              first_n = 1'b0;
              if (tgt == TGT_WR) begin
                st_n = ST_ACK; drv_n = 1'b1; go_tx_n = 1'b0;
                if (first) begin
                  ptr_n = sr;
                end else begin
                  wr_en = (ptr < 8'(NREG));
                  if (ptr != 8'hFF) ptr_n = ptr + 8'd1;
                end
              end else if (tgt == TGT_RDW && first && sr == BLK_CMD) begin
                st_n = ST_ACK; drv_n = 1'b1; go_tx_n = 1'b0;
                cmd_ok_n = 1'b1;
              end else begin
                st_n = ST_IGNORE;
                cmd_ok_n = 1'b0;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (go_tx) begin
              st_n   = ST_TXB;
              txsr_n = tx_byte;
              drv_n  = ~tx_byte[7];
              crc_n  = crc8_step(crc, tx_byte);
              tidx_n = tidx + IDXW'(1);
            end else begin
              st_n  = ST_RXB;
              drv_n = 1'b0;
            end
          end
        end
        ST_TXB: begin
          if (scl_rise && bcnt != 4'd8) begin
            bcnt_n = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            bcnt_n = 4'd0;
            drv_n  = 1'b0;
            st_n   = ST_HACK;
          end else if (scl_fall) begin
            txsr_n = {txsr[6:0], 1'b1};
            drv_n  = ~txsr[6];
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            hack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (hack && tidx <= last_idx) begin
              st_n   = ST_TXB;
              txsr_n = tx_byte;
              drv_n  = ~tx_byte[7];
              crc_n  = crc8_step(crc, tx_byte);
              tidx_n = tidx + IDXW'(1);
            end else begin
              st_n = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st     <= ST_IDLE;
      tgt    <= TGT_NONE;
      sr     <= 8'h00;
      bcnt   <= 4'd0;
      drv    <= 1'b0;
      first  <= 1'b0;
      ptr    <= 8'h00;
      cmd_ok <= 1'b0;
      busy   <= 1'b0;
      crc    <= 8'h00;
      tidx   <= '0;
      txsr   <= 8'hFF;
      hack   <= 1'b0;
      go_tx  <= 1'b0;
    end else begin
      st     <= st_n;
      tgt    <= tgt_n;
      sr     <= sr_n;
      bcnt   <= bcnt_n;
      drv    <= drv_n;
      first  <= first_n;
      ptr    <= ptr_n;
      cmd_ok <= cmd_ok_n;
      busy   <= busy_n;
      crc    <= crc_n;
      tidx   <= tidx_n;
      txsr   <= txsr_n;
      hack   <= hack_n;
      go_tx  <= go_tx_n;
    end
  end

  assign sda_pull_o = drv;

  // controller-written register file
  logic [NREG-1:0][7:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n)                           regs[g] <= 8'h00;
      else if (wr_en && wr_sel == SELW'(g))   regs[g] <= sr;
    end
  end

  assign ctrl_regs_o = regs;

endmodule

// File: rtl/thermal_smb_target_chk.sv
module thermal_smb_target_chk
  import smbt_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int NFLAG  = 4,
  parameter int IDXW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input smbt_state_e      st,
  input logic [7:0]       sr,
  input logic             sda_pull,
  input logic             scl_lvl,
  input logic             awake,
  input logic [6:0]       rd_addr,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] enables,
  input logic             alert_n,
  input logic [IDXW-1:0]  tidx
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R10: the pull-down only starts while SCL is low
  a_r10_pull_starts_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);

  // R10 / R9: idle or ignoring means released
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_IGNORE) |-> !sda_pull);

  // R7: an address acknowledge needs the awake input
  a_r7_asleep_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && $past(st) == ST_ADDR) |-> $past(awake));

  // R2: a read-direction address acknowledge only for the block-read address
  a_r2_read_only_rd_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_pull) && $past(st) == ST_ADDR && $past(sr[0])) |->
      ($past(sr[7:1]) == $past(rd_addr)));

  // R8: alert tracks flag and enable one cycle later
  a_r8_alert_follows: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (alert_n == !$past(|(flags & enables))));

  // R5: the transmit index never runs past the PEC slot
  a_r5_tidx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tidx <= IDXW'(NBYTES + 2));

endmodule

bind thermal_smb_target thermal_smb_target_chk #(
  .NBYTES(NBYTES),
  .NFLAG (NFLAG),
  .IDXW  (IDXW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .st      (st),
  .sr      (sr),
  .sda_pull(sda_pull_o),
  .scl_lvl (scl_lvl),
  .awake   (sys_awake_i),
  .rd_addr (rd_addr_i),
  .flags   (limit_flag_i),
  .enables (alert_en_i),
  .alert_n (alert_n_o),
  .tidx    (tidx)
);

// File: tb/thermal_smb_target_bench.sv
`timescale 1ns/1ps
module thermal_smb_target_bench;

  localparam int NB = 8;
  localparam int NR = 4;
  localparam int NF = 4;
  localparam int H  = 8;
  localparam logic [6:0] WA = 7'h2C;
  localparam logic [6:0] RA = 7'h4B;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           scl_h, sda_h;
  logic           sda_pull;
  logic           awake;
  logic           pec_en;
  logic [NB*8-1:0] blk;
  logic [NR*8-1:0] regs_o;
  logic [NF-1:0]  flags, en;
  logic           alert_n;
  wire            bus_sda = sda_h & ~sda_pull;

  thermal_smb_target #(.NBYTES(NB), .NREG(NR), .NFLAG(NF)) u_thermal_smb_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_h),
    .sda_i       (bus_sda),
    .sda_pull_o  (sda_pull),
    .sys_awake_i (awake),
    .wr_addr_i   (WA),
    .rd_addr_i   (RA),
    .pec_en_i    (pec_en),
    .blk_data_i  (blk),
    .ctrl_regs_o (regs_o),
    .limit_flag_i(flags),
    .alert_en_i  (en),
    .alert_n_o   (alert_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [NR];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ b[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic do_start();
    sda_h = 1'b1; tick(H); scl_h = 1'b1; tick(H);
    sda_h = 1'b0; tick(H); scl_h = 1'b0; tick(H);
  endtask

  task automatic do_stop();
    sda_h = 1'b0; tick(H); scl_h = 1'b1; tick(H); sda_h = 1'b1; tick(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_h = b[i]; tick(H); scl_h = 1'b1; tick(H); scl_h = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output int acked);
    send_bits(b, 8);
    sda_h = 1'b1; tick(H); scl_h = 1'b1; tick(H/2);
    acked = bus_sda ? 0 : 1;
    tick(H/2); scl_h = 1'b0;
  endtask

  task automatic read_byte(input bit host_ack, output logic [7:0] b);
    b = 8'h00;
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(H); scl_h = 1'b1; tick(H/2);
      b = {b[6:0], bus_sda};
      tick(H/2); scl_h = 1'b0;
    end
    sda_h = host_ack ? 1'b0 : 1'b1;
    tick(H); scl_h = 1'b1; tick(H); scl_h = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < NR; r++) chk(tag, int'(regs_o[8*r +: 8]), int'(mdl[r]));
  endtask

  task automatic reg_write(input logic [7:0] p, input int n, input logic [7:0] seed, input string tag);
    int a;
    logic [7:0] d;
    do_start();
    send_byte({WA, 1'b0}, a); chk({tag, " addr ack"}, a, 1);
    send_byte(p, a);          chk({tag, " ptr ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 29);
      send_byte(d, a); chk({tag, " data ack"}, a, 1);
      if (int'(p) + k < NR) mdl[int'(p) + k] = d;
    end
    do_stop(); tick(4);
    check_regs(tag);
  endtask

  task automatic block_read(input string tag);
    int a;
    logic [7:0] c, b;
    c = 8'h00;
    do_start();
    send_byte({RA, 1'b0}, a); chk({tag, " R3 addr ack"}, a, 1); c = bcrc(c, {RA, 1'b0});
    send_byte(8'h40, a);      chk({tag, " R3 cmd ack"}, a, 1);  c = bcrc(c, 8'h40);
    do_start();
    send_byte({RA, 1'b1}, a); chk({tag, " R4 read addr ack"}, a, 1); c = bcrc(c, {RA, 1'b1});
    read_byte(1'b1, b); chk({tag, " R5 count"}, int'(b), NB); c = bcrc(c, b);
    for (int k = 0; k < NB; k++) begin
      read_byte((k != NB - 1) || pec_en, b);
      chk({tag, " R5 data"}, int'(b), int'(blk[8*k +: 8]));
      c = bcrc(c, b);
    end
    if (pec_en) begin
      read_byte(1'b0, b);
      chk({tag, " R6 pec"}, int'(b), int'(c));
    end
    tick(H);
    chk({tag, " R10 released after final byte"}, int'(sda_pull), 0);
    do_stop(); tick(4);
    chk({tag, " R10 idle released"}, int'(sda_pull), 0);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a;
    logic [7:0] b;
    rst_n = 1'b0; scl_h = 1'b1; sda_h = 1'b1; awake = 1'b1; pec_en = 1'b0;
    blk = '0; flags = '0; en = '0;
    for (int r = 0; r < NR; r++) mdl[r] = 8'h00;
    tick(5); rst_n = 1'b1; tick(6);

    chk("R10 reset pull", int'(sda_pull), 0);
    chk("R8 reset alert", int'(alert_n), 1);
    check_regs("R1 reset regs");

    // R1: pointer sweep, auto-increment, and writes past the top
    for (int p = 0; p < NR; p++) reg_write(8'(p), 2, 8'(p * 53 + 7), "R1 sweep");
    reg_write(8'(NR - 1), 3, 8'hA5, "R1 overrun");
    reg_write(8'h80, 1, 8'h3C, "R1 far ptr");

    // R2: read direction on write address
    do_start(); send_byte({WA, 1'b1}, a); chk("R2 read on write addr", a, 0); do_stop();

    // R5/R6: block reads over several data patterns, PEC off and on
    for (int pat = 0; pat < 3; pat++) begin
      for (int k = 0; k < NB; k++) blk[8*k +: 8] = 8'(pat * 37 + k * 11 + 5) ^ 8'(pat << 6);
      pec_en = 1'b0; block_read("R5 nopec");
      pec_en = 1'b1; block_read("R6 pec");
    end

    // R3: wrong command, and extra byte after the command
    do_start(); send_byte({RA, 1'b0}, a); chk("R3 addr", a, 1);
    send_byte(8'h41, a); chk("R3 bad cmd nack", a, 0); do_stop();
    do_start(); send_byte({RA, 1'b0}, a);
    send_byte(8'h40, a); chk("R3 cmd", a, 1);
    send_byte(8'h12, a); chk("R3 extra byte nack", a, 0); do_stop();

    // R4: read without command, and read after a bad command
    do_start(); send_byte({RA, 1'b1}, a); chk("R4 read no cmd", a, 0); do_stop();
    do_start(); send_byte({RA, 1'b0}, a); send_byte(8'h41, a);
    do_start(); send_byte({RA, 1'b1}, a); chk("R4 read after bad cmd", a, 0); do_stop();

    // unknown address
    do_start(); send_byte(8'h22, a); chk("R2 other addr nack", a, 0); do_stop();

    // R7: asleep
    awake = 1'b0;
    do_start(); send_byte({WA, 1'b0}, a); chk("R7 write addr asleep", a, 0); do_stop();
    do_start(); send_byte({RA, 1'b0}, a); chk("R7 read addr asleep", a, 0); do_stop();
    tick(4); check_regs("R7 regs untouched");
    awake = 1'b1;

    // R9: STOP mid-address, then START mid-data
    do_start(); send_bits({WA, 1'b0}, 4); do_stop();
    chk("R9 pull after stop", int'(sda_pull), 0);
    reg_write(8'd1, 1, 8'h9E, "R9 after stop");
    do_start(); send_byte({WA, 1'b0}, a); send_byte(8'd0, a); send_bits(8'hFF, 3);
    do_start(); send_byte({WA, 1'b0}, a); chk("R9 restart addr", a, 1);
    send_byte(8'd2, a); send_byte(8'h5A, a); chk("R9 restart data", a, 1);
    mdl[2] = 8'h5A;
    do_stop(); tick(4); check_regs("R9 restart regs");

    // R8: full alert sweep
    for (int f = 0; f < (1 << NF); f++) begin
      for (int e = 0; e < (1 << NF); e++) begin
        flags = NF'(f); en = NF'(e);
        tick(3);
        chk("R8 alert", int'(alert_n), ((f & e) != 0) ? 0 : 1);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule